// File: doc/BRIEF.md
# Twin-Predicated Vector Step Sequencer

This controller runs one vector loop of length `vl_i` under two predicate masks. One mask selects source elements and the other selects destination elements. A start request captures the vector length and the two "all ones" flags. The controller then waits for both mask words. Next it walks a source step and a destination step forward together. Each step skips the zero bits of its own mask on its own. The result pairs the k-th selected source element with the k-th selected destination element, so one pass behaves like a compress of the source followed by an expand into the destination.

Each iteration runs in a fixed order: skip, decode, execute. In the skip cycle both steps move to the next set bit of their masks. The decode cycle follows, so decoding sees the final step values. In the execute cycle the controller presents the step pair with `exec_valid_o` and holds it until the execute unit acknowledges. The loop ends when either step would reach or pass the vector length, or when either mask has no set bits left. The end is signalled by a one-cycle `done_o` pulse.

Top module: `twin_pred_seq`

## Requirements
- R1: After reset, `exec_valid_o`, `done_o` and `mask_req_o` are all low, and the block waits for `start_i`.
- R2: When `start_i` arrives with `vl_i` equal to 0, `done_o` is high in the cycle after the start edge, and no execute is presented.
- R3: While waiting for masks, `mask_req_o` is high if either all-ones flag is low. The wait ends on the clock edge where `mask_ready_i` is high. If both flags are high, no request is made and the wait lasts exactly one cycle.
- R4: For the k-th iteration (k = 0, 1, ...), `srcstep_o` equals the bit index of the k-th set bit of the source mask, and `dststep_o` equals the bit index of the k-th set bit of the destination mask. Bit 0 is element 0.
- R5: When either the next source index or the next destination index is greater than or equal to VL, the loop ends without presenting that pair.
- R6: When either mask has no set bits left, the loop ends.
- R7: Each iteration spends one cycle in skip and one cycle in decode. `exec_valid_o` rises two cycles after the skip cycle begins.
- R8: `exec_valid_o` stays high, and `srcstep_o` and `dststep_o` stay stable, until a clock edge where `exec_ack_i` is high.
- R9: `done_o` is high for exactly one cycle. The block then returns to idle and accepts a new start.
- R10: When an all-ones flag is high, the corresponding mask input is ignored and treated as all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a loop; sampled while idle |
| vl_i | input | 7 | Vector length, 0 to 64 |
| src_all_i | input | 1 | Source mask is all ones, so no fetch is needed |
| dst_all_i | input | 1 | Destination mask is all ones, so no fetch is needed |
| mask_req_o | output | 1 | Request for mask words |
| mask_ready_i | input | 1 | Mask words are valid |
| src_mask_i | input | 64 | Source predicate mask |
| dst_mask_i | input | 64 | Destination predicate mask |
| srcstep_o | output | 7 | Current source element index |
| dststep_o | output | 7 | Current destination element index |
| exec_valid_o | output | 1 | Step pair is ready for execution |
| exec_ack_i | input | 1 | Execute unit accepts the pair |
| done_o | output | 1 | One-cycle end-of-loop pulse |

## Verification
The bench drives its inputs at falling edges and samples the outputs at falling edges. It works out from the requirements which cycle each result belongs to. `mask_req_o` is due one cycle after the start edge. `done_o` is due one cycle after start when VL is zero. Otherwise, after the mask wait, each pair appears on `exec_valid_o` exactly two cycles after its skip cycle begins, and it is checked on every cycle it is held. The closing `done_o` is due two cycles after the last acknowledge and must be gone one cycle later. The expected step pairs come from the bench's own list of the k-th set bits of each mask, cut at VL.

// File: rtl/twin_pred_pkg.sv
package twin_pred_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SKIP, ST_DECODE, ST_EXEC, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/tz_enc.sv
module tz_enc #(
  parameter int W  = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          empty_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--)
      if (vec_i[i]) idx_o = IW'(i);
  end
  assign empty_o = ~|vec_i;
endmodule

// File: rtl/step_lane.sv
module step_lane #(
  parameter int W  = 64,
  localparam int IW = $clog2(W),
  localparam int VW = $clog2(W + 1),
  localparam int SW = VW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [W-1:0]  mask_i,
  input  logic          adv_i,
  output logic [SW-1:0] cand_o,
  output logic          empty_o,
  output logic [VW-1:0] step_o
);
  logic [W-1:0]  mask_q;
  logic [VW-1:0] base_q;
  logic [IW-1:0] tz;
  logic [IW:0]   shamt;

  tz_enc #(.W(W)) u_tz (.vec_i(mask_q), .idx_o(tz), .empty_o(empty_o));

  assign cand_o = SW'(base_q) + SW'(tz);
  assign shamt  = {1'b0, tz} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= '0;
      step_o <= '0;
    end else if (load_i) begin
      mask_q <= mask_i;
      base_q <= '0;
      step_o <= '0;
    end else if (adv_i) begin
      step_o <= cand_o[VW-1:0];
      base_q <= VW'(cand_o + 1'b1);
      mask_q <= mask_q >> shamt;
    end
  end

  // the element chosen must have its bit set in the remaining mask
  assert_adv_hits_set_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> (!empty_o && mask_q[tz]));
  assert_step_moves_up_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && base_q != '0) |=> (step_o > $past(step_o)));
endmodule

// File: rtl/twin_pred_seq.sv
module twin_pred_seq
  import twin_pred_pkg::*;
#(
  parameter int W  = 64,
  localparam int VW = $clog2(W + 1),
  localparam int SW = VW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [VW-1:0] vl_i,
  input  logic          src_all_i,
  input  logic          dst_all_i,
  output logic          mask_req_o,
  input  logic          mask_ready_i,
  input  logic [W-1:0]  src_mask_i,
  input  logic [W-1:0]  dst_mask_i,
  output logic [VW-1:0] srcstep_o,
  output logic [VW-1:0] dststep_o,
  output logic          exec_valid_o,
  input  logic          exec_ack_i,
  output logic          done_o
);
  seq_state_e    state_q, state_d;
  logic [VW-1:0] vl_q;
  logic          src_all_q, dst_all_q;
  logic          masks_go, load, adv, finish;
  logic [SW-1:0] src_cand, dst_cand;
  logic          src_empty, dst_empty;

  assign masks_go = (src_all_q && dst_all_q) || mask_ready_i;
  assign load     = (state_q == ST_WAIT) && masks_go;
  assign finish   = src_empty || dst_empty ||
                    (src_cand >= SW'(vl_q)) || (dst_cand >= SW'(vl_q));
  assign adv      = (state_q == ST_SKIP) && !finish;

  step_lane #(.W(W)) u_src (
    .clk_i, .rst_ni, .load_i(load),
    .mask_i(src_all_q ? {W{1'b1}} : src_mask_i),
    .adv_i(adv), .cand_o(src_cand), .empty_o(src_empty), .step_o(srcstep_o));

  step_lane #(.W(W)) u_dst (
    .clk_i, .rst_ni, .load_i(load),
    .mask_i(dst_all_q ? {W{1'b1}} : dst_mask_i),
    .adv_i(adv), .cand_o(dst_cand), .empty_o(dst_empty), .step_o(dststep_o));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = (vl_i == '0) ? ST_DONE : ST_WAIT;
      ST_WAIT:   if (masks_go) state_d = ST_SKIP;
      ST_SKIP:   state_d = finish ? ST_DONE : ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC:   if (exec_ack_i) state_d = ST_SKIP;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      vl_q      <= '0;
      src_all_q <= 1'b0;
      dst_all_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        vl_q      <= vl_i;
        src_all_q <= src_all_i;
        dst_all_q <= dst_all_i;
      end
    end
  end

  assign mask_req_o   = (state_q == ST_WAIT) && !(src_all_q && dst_all_q);
  assign exec_valid_o = (state_q == ST_EXEC);
  assign done_o       = (state_q == ST_DONE);

  assert_exec_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_valid_o |-> (srcstep_o < vl_q && dststep_o < vl_q));
  assert_exec_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && !exec_ack_i) |=>
      (exec_valid_o && $stable(srcstep_o) && $stable(dststep_o)));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_no_req_when_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_all_q && dst_all_q) |-> !mask_req_o);
  assert_excl_outputs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && (exec_valid_o || mask_req_o)));
  assert_decode_before_exec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exec_valid_o) |-> ($past(state_q) == ST_DECODE));
endmodule

// File: tb/sim_twin_pred_seq.sv
module sim_twin_pred_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [6:0]  vl = '0;
  logic        sa = 1'b0, da = 1'b0;
  logic        mreq, mrdy = 1'b0;
  logic [63:0] sm = '0, dm = '0;
  logic [6:0]  ss, ds;
  logic        ev, ack = 1'b0, done;
  int n_cmp = 0, n_bad = 0;

  always #2ns clk = ~clk;

  twin_pred_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .vl_i(vl),
    .src_all_i(sa), .dst_all_i(da), .mask_req_o(mreq), .mask_ready_i(mrdy),
    .src_mask_i(sm), .dst_mask_i(dm), .srcstep_o(ss), .dststep_o(ds),
    .exec_valid_o(ev), .exec_ack_i(ack), .done_o(done));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int kth_bit(input logic [63:0] m, input int k);
    int c = 0;
    for (int i = 0; i < 64; i++)
      if (m[i]) begin
        if (c == k) return i;
        c++;
      end
    return 64;
  endfunction

  task automatic run(input int v, input logic [63:0] s_m, input logic [63:0] d_m,
                     input bit s_a, input bit d_a, input int rdly, input int adly);
    int exp_s[$], exp_d[$];
    logic [63:0] es = s_a ? '1 : s_m;
    logic [63:0] ed = d_a ? '1 : d_m;
    for (int k = 0; k < 64; k++) begin
      int a = kth_bit(es, k);
      int b = kth_bit(ed, k);
      if (a >= v || b >= v) break;
      exp_s.push_back(a);
      exp_d.push_back(b);
    end
    @(negedge clk);
    start = 1'b1; vl = 7'(v); sm = s_m; dm = d_m; sa = s_a; da = d_a;
    @(negedge clk);
    start = 1'b0;
    if (v == 0) begin
      chk(done === 1'b1, "R2 done after zero VL", int'(done), 1);
      chk(ev === 1'b0, "R2 no exec", int'(ev), 0);
      @(negedge clk);
      chk(done === 1'b0, "R9 pulse ends", int'(done), 0);
      return;
    end
    chk(mreq === !(s_a && d_a), "R3 mask request", int'(mreq), int'(!(s_a && d_a)));
    if (!(s_a && d_a)) begin
      for (int i = 0; i < rdly; i++) begin
        @(negedge clk);
        chk(mreq === 1'b1, "R3 request held", int'(mreq), 1);
      end
      mrdy = 1'b1;
      @(negedge clk);
      mrdy = 1'b0;
    end else begin
      @(negedge clk);
    end
    foreach (exp_s[j]) begin
      chk(ev === 1'b0, "R7 skip cycle", int'(ev), 0);
      @(negedge clk);
      chk(ev === 1'b0, "R7 decode cycle", int'(ev), 0);
      @(negedge clk);
      chk(ev === 1'b1, "R7 exec valid", int'(ev), 1);
      chk(ss == 7'(exp_s[j]), "R4 srcstep", int'(ss), exp_s[j]);
      chk(ds == 7'(exp_d[j]), "R4 dststep", int'(ds), exp_d[j]);
      for (int i = 0; i < adly; i++) begin
        @(negedge clk);
        chk(ev === 1'b1 && ss == 7'(exp_s[j]) && ds == 7'(exp_d[j]),
            "R8 held until ack", int'(ss), exp_s[j]);
      end
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
    end
    chk(done === 1'b0 && ev === 1'b0, "R5 skip before end", int'(done), 0);
    @(negedge clk);
    chk(done === 1'b1, "R5 R6 loop ends", int'(done), 1);
    chk(ev === 1'b0, "R5 no extra exec", int'(ev), 0);
    @(negedge clk);
    chk(done === 1'b0 && ev === 1'b0, "R9 single pulse", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ev === 1'b0 && done === 1'b0 && mreq === 1'b0, "R1 reset outputs", int'(ev), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev === 1'b0 && done === 1'b0 && mreq === 1'b0, "R1 idle outputs", int'(mreq), 0);
    run(5, '0, '0, 1'b1, 1'b1, 0, 0);                        // R10 masks ignored
    run(8, 64'h16, 64'h0D, 1'b0, 1'b0, 2, 1);                // R4 compress/expand
    run(0, '1, '1, 1'b1, 1'b1, 0, 0);                        // R2
    run(10, 64'h0, 64'hFF, 1'b0, 1'b0, 0, 0);                // R6 empty mask
    run(6, 64'h204, 64'h3, 1'b0, 1'b0, 1, 0);                // R5 VL cut
    run(64, 64'h8000_0000_0000_0001, '0, 1'b0, 1'b1, 0, 2);  // R4 top bit
    run(12, 64'hA5A, 64'h0, 1'b0, 1'b1, 3, 0);               // R10 dst all
    run(64, '0, '0, 1'b1, 1'b1, 0, 0);                       // R4 full length
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule